// File: doc/BRIEF.md
# Page Invalidation Shootdown Sequencer

This block coordinates the removal of one stale virtual-to-physical translation from the private translation caches of several cores. A core that has already rewritten the shared page-table entry, and still holds the page-table lock, hands the sequencer a virtual page number and a bit-vector of cores that may have cached the old mapping. The sequencer sends an invalidate request that carries the page number to every selected core in the same cycle. It then records one acknowledgment from each of them and signals completion only when the whole set has answered. Only after that completion pulse may software reuse the physical page.

A responder returns its acknowledgment once its local flush has finished. A core whose interrupts are masked does not react to the request until it unmasks them, so one slow core holds back the whole operation. A programmable watchdog counter flags an operation whose acknowledgments are overdue, but the sequencer keeps waiting. A new request that arrives while an operation is in flight is refused rather than queued. Acknowledgments that are not expected are dropped and leave a sticky error flag.

Top module: `shoot_coord`

## Requirements
- R1: A request on `start_i` is accepted only in a cycle where the sequencer is idle and `lock_held_i` is high. A request without the lock has no effect: `busy_o` stays low and no invalidate is issued.
- R2: In the cycle after acceptance, `inv_req_o` equals the accepted target vector for exactly one cycle, and `inv_vpn_o` carries the accepted page number. Bit i of the vector addresses core i.
- R3: `done_o` is a single-cycle pulse. It is raised only after every targeted core has acknowledged. In the cycle after the pulse, `busy_o` is low.
- R4: A request while `busy_o` is high raises `refused_o` in that same cycle. The request is not queued, and no second invalidate follows the current operation.
- R5: An acknowledgment from a core outside the target vector, or a second acknowledgment from a core that already answered, does not count toward completion. It sets `proto_err_o`, which stays high until reset.
- R6: If acknowledgments are still missing after the wait phase has lasted `tmo_limit_i` cycles, `timeout_o` rises. The sequencer keeps waiting and still completes normally. `timeout_o` stays high until the next accepted request clears it, and it never rises when every acknowledgment arrives within the limit.
- R7: A targeted core that holds back its acknowledgment, for example while its interrupts are masked, delays `done_o` for as long as it does so.
- R8: Every core index is treated alike, including the requesting core itself. A vector that selects all cores completes only after all of them have acknowledged.
- R9: After reset, `busy_o`, `done_o`, `refused_o`, `timeout_o`, `proto_err_o` and `inv_req_o` are all zero.
- R10: An all-zero target vector issues no invalidate and produces a `done_o` pulse within four cycles of acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a shootdown |
| lock_held_i | input | 1 | Requester holds the page-table lock |
| vpn_i | input | VPN_W | Virtual page number to invalidate |
| targets_i | input | NCORES | One bit per core that may hold the mapping |
| tmo_limit_i | input | TMO_W | Wait-phase cycles before the overdue flag |
| ack_i | input | NCORES | Per-core acknowledgment pulses |
| inv_req_o | output | NCORES | Per-core invalidate request pulses |
| inv_vpn_o | output | VPN_W | Page number carried with the request |
| busy_o | output | 1 | Operation in progress |
| refused_o | output | 1 | Request rejected because busy |
| done_o | output | 1 | All targeted acknowledgments received |
| timeout_o | output | 1 | Acknowledgments overdue |
| proto_err_o | output | 1 | Sticky: unexpected acknowledgment seen |

## Verification
The main function is exercised with sparse, full, single-core and empty target vectors. Each responder has its own delay, so completion order differs from request order, and the bench can tell a sequencer that waits for the full set from one that stops at the first or the last answer. Stray and duplicate acknowledgments are injected while other targets are still outstanding, which separates a design that wrongly counts them from one that drops them. A responder held silent beyond the watchdog limit shows that the overdue flag and continued waiting coexist. A fast run with a generous limit shows that the flag is not raised spuriously.

// File: rtl/shoot_pkg.sv
package shoot_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_WAIT = 2'd2,
      ST_DONE = 2'd3
   } shoot_st_e;
endpackage

// File: rtl/shoot_fsm.sv
module shoot_fsm
   import shoot_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_i,
   input  logic      lock_held_i,
   input  logic      all_acked_i,
   output shoot_st_e state_o,
   output logic      accept_o,
   output logic      refused_o,
   output logic      busy_o,
   output logic      done_o
);
   shoot_st_e st_q, st_d;

   assign accept_o  = (st_q == ST_IDLE) && start_i && lock_held_i;
   assign refused_o = (st_q != ST_IDLE) && start_i;
   assign busy_o    = (st_q != ST_IDLE);
   assign done_o    = (st_q == ST_DONE);
   assign state_o   = st_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (accept_o) st_d = ST_SEND;
         ST_SEND: st_d = ST_WAIT;
         ST_WAIT: if (all_acked_i) st_d = ST_DONE;
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   // R3
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R1
   accept_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i && lock_held_i));
endmodule

// File: rtl/shoot_ack_track.sv
module shoot_ack_track #(
   parameter int NCORES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [NCORES-1:0] mask_i,
   input  logic [NCORES-1:0] ack_i,
   output logic [NCORES-1:0] pending_o,
   output logic              all_acked_o,
   output logic              proto_err_o
);
   logic [NCORES-1:0] pend_q;
   logic [NCORES-1:0] stray;

   for (genvar c = 0; c < NCORES; c++) begin : g_core
      assign stray[c] = ack_i[c] & ~pend_q[c];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pend_q[c] <= 1'b0;
         else if (load_i) pend_q[c] <= mask_i[c];
         else if (ack_i[c]) pend_q[c] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      proto_err_o <= 1'b0;
      else if (|stray) proto_err_o <= 1'b1;
   end

   assign pending_o   = pend_q;
   assign all_acked_o = (pend_q == '0);

   // R5
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err_o |=> proto_err_o);
endmodule

// File: rtl/shoot_timer.sv
module shoot_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             run_i,
   input  logic             missing_i,
   input  logic [TMO_W-1:0] limit_i,
   output logic             timeout_o
);
   logic [TMO_W-1:0] cnt_q;
   logic             expired;

   assign expired = (cnt_q >= limit_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         timeout_o <= 1'b0;
      end else if (clear_i) begin
         cnt_q     <= '0;
         timeout_o <= 1'b0;
      end else if (run_i) begin
         if (!expired) cnt_q <= cnt_q + 1'b1;
         if (expired && missing_i) timeout_o <= 1'b1;
      end
   end

   // R6
   tmo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_o) |-> $past(missing_i && run_i));
endmodule

// File: rtl/shoot_coord.sv
module shoot_coord
   import shoot_pkg::*;
#(
   parameter int NCORES = 8,
   parameter int VPN_W  = 20,
   parameter int TMO_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              lock_held_i,
   input  logic [VPN_W-1:0]  vpn_i,
   input  logic [NCORES-1:0] targets_i,
   input  logic [TMO_W-1:0]  tmo_limit_i,
   input  logic [NCORES-1:0] ack_i,
   output logic [NCORES-1:0] inv_req_o,
   output logic [VPN_W-1:0]  inv_vpn_o,
   output logic              busy_o,
   output logic              refused_o,
   output logic              done_o,
   output logic              timeout_o,
   output logic              proto_err_o
);
   if (NCORES < 1 || NCORES > 256) begin : g_bad_ncores
      $error("shoot_coord: NCORES out of range");
   end
   if (VPN_W < 1 || TMO_W < 2) begin : g_bad_width
      $error("shoot_coord: width parameter out of range");
   end

   shoot_st_e         state;
   logic              accept;
   logic              all_acked;
   logic [NCORES-1:0] pending;
   logic [NCORES-1:0] mask_q;
   logic [VPN_W-1:0]  vpn_q;

   shoot_fsm u_fsm (
      .clk, .rst_n, .start_i, .lock_held_i,
      .all_acked_i (all_acked),
      .state_o     (state),
      .accept_o    (accept),
      .refused_o   (refused_o),
      .busy_o      (busy_o),
      .done_o      (done_o)
   );

   shoot_ack_track #(.NCORES(NCORES)) u_track (
      .clk, .rst_n,
      .load_i      (accept),
      .mask_i      (targets_i),
      .ack_i       (ack_i),
      .pending_o   (pending),
      .all_acked_o (all_acked),
      .proto_err_o (proto_err_o)
   );

   shoot_timer #(.TMO_W(TMO_W)) u_timer (
      .clk, .rst_n,
      .clear_i   (accept),
      .run_i     (state == ST_WAIT),
      .missing_i (!all_acked),
      .limit_i   (tmo_limit_i),
      .timeout_o (timeout_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         vpn_q  <= '0;
      end else if (accept) begin
         mask_q <= targets_i;
         vpn_q  <= vpn_i;
      end
   end

   assign inv_req_o = (state == ST_SEND) ? mask_q : '0;
   assign inv_vpn_o = vpn_q;

   // R3
   done_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pending == '0));

   // R2
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_req_o != '0) |=> (inv_req_o == '0));

   // R4
   refuse_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (refused_o && !done_o) |=> busy_o && (inv_req_o == '0));
endmodule

// File: tb/shoot_coord_tb_top.sv
module shoot_coord_tb_top;
   localparam int NC = 8;
   localparam int VW = 20;
   localparam int TW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          lock_held_i = 1'b0;
   logic [VW-1:0] vpn_i = '0;
   logic [NC-1:0] targets_i = '0;
   logic [TW-1:0] tmo_limit_i = 16'd200;
   logic [NC-1:0] stray_ack = '0;
   logic [NC-1:0] resp_ack;
   logic [NC-1:0] flush_done;
   logic [NC-1:0] ack_i;
   logic [NC-1:0] inv_req_o;
   logic [VW-1:0] inv_vpn_o;
   logic busy_o, refused_o, done_o, timeout_o, proto_err_o;

   int  delay [NC];
   logic [NC-1:0] irq_off = '0;
   logic [NC-1:0] acked_seen;
   logic          seen_clr = 1'b0;
   int  req_pulses;
   int  n_checks = 0;
   int  n_fail = 0;
   int  cyc = 0;

   always #5 clk = ~clk;

   assign ack_i = resp_ack | stray_ack;

   shoot_coord #(.NCORES(NC), .VPN_W(VW), .TMO_W(TW)) dut_i (
      .clk, .rst_n, .start_i, .lock_held_i, .vpn_i, .targets_i,
      .tmo_limit_i, .ack_i, .inv_req_o, .inv_vpn_o, .busy_o,
      .refused_o, .done_o, .timeout_o, .proto_err_o
   );

   // responders: flush after delay (and only while interrupts are on), ack after flush
   for (genvar c = 0; c < NC; c++) begin : g_resp
      logic armed;
      int   cnt;
      always @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            armed <= 1'b0; cnt <= 0;
            flush_done[c] <= 1'b0; resp_ack[c] <= 1'b0;
         end else begin
            flush_done[c] <= 1'b0;
            resp_ack[c]   <= flush_done[c];
            if (inv_req_o[c]) begin
               armed <= 1'b1; cnt <= delay[c];
            end else if (armed && !irq_off[c]) begin
               if (cnt > 0) cnt <= cnt - 1;
               else begin flush_done[c] <= 1'b1; armed <= 1'b0; end
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (seen_clr) begin acked_seen <= '0; req_pulses <= 0; end
      else begin
         acked_seen <= acked_seen | resp_ack;
         if (inv_req_o != '0) req_pulses <= req_pulses + 1;
      end
      if (cyc > 150000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; start_i = 0; stray_ack = '0; irq_off = '0;
      seen_clr = 1;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      @(negedge clk); seen_clr = 0;
   endtask

   task automatic set_delays(input int base);
      for (int c = 0; c < NC; c++) delay[c] = base + 3 * ((c * 5) % NC);
   endtask

   // pulse start at a negedge; returns after the following negedge (SEND cycle)
   task automatic kick(input logic [NC-1:0] m, input logic [VW-1:0] v, input bit lock);
      seen_clr = 1;
      targets_i = m; vpn_i = v; lock_held_i = lock; start_i = 1;
      @(negedge clk);
      start_i = 0; lock_held_i = 0; seen_clr = 0;
   endtask

   task automatic wait_done(input string req, output int cycles);
      cycles = 0;
      while (!done_o && cycles < 2000) begin @(negedge clk); cycles++; end
      check(done_o == 1'b1, req, "done pulse seen", done_o, 1);
   endtask

   task automatic finish_op(input string req, input logic [NC-1:0] m);
      check(acked_seen == m, req, "all targets acked at done", acked_seen, m);
      @(negedge clk);
      check(done_o == 1'b0, req, "done one cycle", done_o, 0);
      check(busy_o == 1'b0, req, "idle after done", busy_o, 0);
   endtask

   task automatic t_reset();
      check(busy_o == 0 && done_o == 0 && refused_o == 0, "R9", "ctrl flags", {busy_o, done_o, refused_o}, 0);
      check(timeout_o == 0 && proto_err_o == 0, "R9", "status flags", {timeout_o, proto_err_o}, 0);
      check(inv_req_o == '0, "R9", "no request", inv_req_o, 0);
   endtask

   task automatic t_basic(input logic [NC-1:0] m, input logic [VW-1:0] v, input string req);
      int n;
      set_delays(2);
      kick(m, v, 1);
      check(inv_req_o == m, "R2", "request vector", inv_req_o, m);
      check(inv_vpn_o == v, "R2", "request page", inv_vpn_o, v);
      @(negedge clk);
      check(inv_req_o == '0, "R2", "request one cycle", inv_req_o, 0);
      wait_done(req, n);
      finish_op(req, m);
      check(req_pulses == 1, "R2", "single request pulse", req_pulses, 1);
      check(timeout_o == 0, "R6", "no timeout when in time", timeout_o, 0);
   endtask

   task automatic t_nolock();
      kick(8'h0F, 20'h1234, 0);
      check(busy_o == 0, "R1", "start without lock ignored", busy_o, 0);
      check(inv_req_o == '0, "R1", "no request without lock", inv_req_o, 0);
      @(negedge clk);
      check(busy_o == 0, "R1", "still idle", busy_o, 0);
   endtask

   task automatic t_refuse();
      int n;
      set_delays(8);
      kick(8'h21, 20'hABCDE, 1);
      repeat (3) @(negedge clk);
      targets_i = 8'hC0; lock_held_i = 1; start_i = 1; #1;
      check(refused_o == 1, "R4", "busy start refused", refused_o, 1);
      @(negedge clk); start_i = 0; lock_held_i = 0;
      wait_done("R4", n);
      finish_op("R4", 8'h21);
      repeat (4) @(negedge clk);
      check(busy_o == 0 && req_pulses == 1, "R4", "refused start not queued", req_pulses, 1);
   endtask

   task automatic t_stray();
      int n;
      do_reset();
      set_delays(10);
      kick(8'h03, 20'h00042, 1);
      @(negedge clk);
      stray_ack = 8'h20; @(negedge clk); stray_ack = '0;
      check(proto_err_o == 1, "R5", "out-of-mask ack flagged", proto_err_o, 1);
      check(busy_o == 1, "R5", "stray ack does not complete", busy_o, 1);
      wait_done("R5", n);
      finish_op("R5", 8'h03);
      check(proto_err_o == 1, "R5", "error sticky", proto_err_o, 1);
   endtask

   task automatic t_dup();
      int n;
      do_reset();
      delay[0] = 0; delay[1] = 25;
      kick(8'h03, 20'h00077, 1);
      while (!acked_seen[0]) @(negedge clk);
      check(proto_err_o == 0, "R5", "no error before duplicate", proto_err_o, 0);
      stray_ack = 8'h01; @(negedge clk); stray_ack = '0;
      check(proto_err_o == 1, "R5", "duplicate ack flagged", proto_err_o, 1);
      @(negedge clk);
      check(busy_o == 1 && done_o == 0, "R5", "duplicate does not complete", busy_o, 1);
      wait_done("R5", n);
      finish_op("R5", 8'h03);
   endtask

   task automatic t_masked();
      int n;
      do_reset();
      set_delays(1);
      tmo_limit_i = 16'd5;
      irq_off = 8'h08;
      kick(8'h0C, 20'h55555, 1);
      repeat (30) @(negedge clk);
      check(busy_o == 1 && done_o == 0, "R7", "masked target stalls op", busy_o, 1);
      check(timeout_o == 1, "R6", "overdue flag raised", timeout_o, 1);
      irq_off = '0;
      wait_done("R7", n);
      finish_op("R7", 8'h0C);
      check(timeout_o == 1, "R6", "flag held until next start", timeout_o, 1);
      tmo_limit_i = 16'd200;
      t_basic(8'h01, 20'h00001, "R6");
   endtask

   task automatic t_empty();
      int n;
      kick(8'h00, 20'h0BEEF, 1);
      check(inv_req_o == '0, "R10", "no request for empty vector", inv_req_o, 0);
      wait_done("R10", n);
      check(n <= 3, "R10", "prompt done", n, 3);
      finish_op("R10", 8'h00);
   endtask

   initial begin
      set_delays(2);
      acked_seen = '0; req_pulses = 0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic(8'hA5, 20'h12345, "R3");
      t_basic(8'h40, 20'h00ABC, "R3");
      t_nolock();
      t_refuse();
      t_stray();
      t_dup();
      t_masked();
      t_basic(8'hFF, 20'hFFFFF, "R8");
      t_empty();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule